// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles. It does not pass the words through a chain of registers. Each word is written once into a dual-port storage array and read back later. Two address counters do the moving: a write pointer and a read pointer. Both advance on every clock and wrap around the array. The delay therefore costs one array entry per cycle of delay plus two small counters, which makes long delays cheap compared with a flip-flop chain.

A small controller with two states sits beside the pointers. After reset the block is in `ST_FILL`, where the array holds nothing valid yet and the output is held at zero. Once the pointers have covered the whole array, the controller moves to `ST_RUN` (transition "fill complete") and stays there until the next reset (transition "reset", from either state back to `ST_FILL`). In `ST_RUN` the output shows the stored words. The storage array has no reset, so the state gating is what keeps stale contents off the output.

Top module: `dly_ram_line`

## Requirements
- R1: With edges counted from 1 at the first rising edge where reset is low, the output after edge n equals the input sampled at edge n-DEPTH, for every n > DEPTH. The latency is therefore exactly DEPTH cycles.
- R2: While reset is high at a rising edge, the output is zero after that edge. Reset loads the read pointer with 0 and the write pointer with DEPTH-1 (all ones).
- R3: Outside reset, the write pointer always sits exactly one entry behind the read pointer, modulo DEPTH.
- R4: Both pointers advance by one on every clock edge outside reset and wrap from DEPTH-1 to 0. Data stays correct over many wraps.
- R5: The controller stays in `ST_FILL` for exactly DEPTH edges after reset and then enters `ST_RUN` with the read pointer back at 0. It leaves `ST_RUN` only through reset.
- R6: While the controller is in `ST_FILL`, the output is zero after every edge, whatever the input is.
- R7: A reset in the middle of a run restarts the fill. For DEPTH edges the output is zero, and words written before the reset never appear on the output.
- R8: DEPTH must be a power of two. The pointers are log2(DEPTH) bits wide, and any other depth is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Word entering the delay line |
| dout | output | DATA_W | Word leaving the delay line, DEPTH cycles later |

## Verification
The hardest case to reach is a reset that lands while the array is full of valid, distinctive words. The old contents are still physically present in the array. Only the fill gating keeps them off the output, and the window closes on one exact edge. The stimulus first runs the line through several wraps and then floods it with an all-ones pattern. It resets mid-stream and then feeds a ramp. The scoreboard expects zero for exactly DEPTH edges and the first ramp value on edge DEPTH+1, so a leak of old data or a fill window that is one edge off shows up as a mismatch.

// File: rtl/dly_ram_pkg.sv
package dly_ram_pkg;

    // Controller states of the delay line
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,   // array not yet primed, output forced to zero
        ST_RUN  = 1'b1    // array primed, output shows stored words
    } dly_state_e;

endpackage

// File: rtl/dly_ptr_ctr.sv
module dly_ptr_ctr #(
    parameter int unsigned AW = 4,
    parameter logic [AW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Free-running wrap-around address counter
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= INIT;
        end else begin
            ptr <= ptr + ONE;
        end
    end

    AST_PTR_INIT: assert property (@(posedge clk)
        rst |=> (ptr == INIT));                                          // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ptr == $past(ptr) + ONE));                      // R4

endmodule

// File: rtl/dly_dpram.sv
module dly_dpram #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    // Registered read: returns the old word even when the same entry is written
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/dly_ram_line.sv
module dly_ram_line
    import dly_ram_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned    AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0]  RD_START = '0;
    localparam logic [AW-1:0]  WR_START = '1;
    localparam logic [AW-1:0]  LAST     = AW'(DEPTH - 1);

    // R8: only power-of-two depths wrap cleanly
    if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
        $error("dly_ram_line: DEPTH must be a power of two >= 2");
    end

    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     wr_ptr;
    logic [DATA_W-1:0] ram_q;
    dly_state_e        state_q;
    dly_state_e        state_d;

    dly_ptr_ctr #(.AW(AW), .INIT(RD_START)) u_rd_ctr (
        .clk (clk),
        .rst (rst),
        .ptr (rd_ptr)
    );

    dly_ptr_ctr #(.AW(AW), .INIT(WR_START)) u_wr_ctr (
        .clk (clk),
        .rst (rst),
        .ptr (wr_ptr)
    );

    dly_dpram #(.DW(DATA_W), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (1'b1),
        .waddr (wr_ptr),
        .wdata (din),
        .raddr (rd_ptr),
        .rdata (ram_q)
    );

    // Next-state logic: fill ends when the read pointer reaches the last entry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (rd_ptr == LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, gated by state
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            unique case (state_q)
                ST_FILL: dout <= '0;
                ST_RUN:  dout <= ram_q;
                default: dout <= '0;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ((dout == '0) && (state_q == ST_FILL)));                 // R2

    AST_PTR_TRAIL: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wr_ptr == rd_ptr - AW'(1)));                    // R3

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(state_q == ST_RUN)) |-> (rd_ptr == '0));   // R5

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));                    // R5

    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |=> (dout == '0));                          // R6

endmodule

// File: tb/sim_dly_ram_line.sv
`timescale 1ns/1ps
module sim_dly_ram_line;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;

    int total = 0;
    int bad   = 0;
    bit in_rst = 1'b1;
    bit done   = 1'b0;
    bit rerun  = 1'b0;   // set after a mid-run reset
    logic [DATA_W-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    dly_ram_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (dout)
    );

    task automatic check(input logic [DATA_W-1:0] exp, input string req);
        total++;
        if (dout !== exp) begin
            bad++;
            $display("FAIL %s: dout=%h expected=%h at %0t", req, dout, exp, $time);
        end
    endtask

    // Driver: called at a falling edge, returns at the next falling edge
    task automatic step(input logic [DATA_W-1:0] v);
        din = v;
        @(posedge clk);
        exp_q.push_back(v);
        @(negedge clk);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        in_rst = 1'b1;
        exp_q.delete();
        repeat (cycles) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b0;
        in_rst = 1'b0;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!done) begin
                if (in_rst) begin
                    check('0, "R2");                     // reset clears the output
                end else if (exp_q.size() > DEPTH) begin
                    // R1 latency; R3, R4 pointer spacing and wrap seen through data
                    check(exp_q.pop_front(), "R1,R4");
                end else if (rerun) begin
                    check('0, "R7");                     // refill after mid-run reset
                end else begin
                    check('0, "R6,R5");                  // fill window zero
                end
            end
        end
    end

    // Watchdog
    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // Random data across several wraps (R1, R4, R8 power-of-two wrap)
        for (int i = 0; i < 5 * DEPTH; i++) step(DATA_W'($urandom));
        // Fill the array with a distinctive pattern
        for (int i = 0; i < 2 * DEPTH; i++) step('1);
        // Mid-run reset: stale all-ones must not leak (R7)
        rerun = 1'b1;
        do_reset(2);
        for (int i = 0; i < 3 * DEPTH; i++) step(DATA_W'(i + 1));
        for (int i = 0; i < 4 * DEPTH; i++) step(DATA_W'($urandom));
        // Alternating pattern at the tail
        for (int i = 0; i < 2 * DEPTH; i++) step((i % 2 == 0) ? 8'hA5 : 8'h5A);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule